// File: doc/BRIEF.md
# Bitstream Input Fetcher

This block pulls a compressed bitstream out of main memory and hands it, one byte per cycle, to the input FIFO of a decoder. Software programs a byte address and a byte count through a small register port. A nonzero count starts the transfer. The block issues word-aligned 32-bit reads, one at a time. It drops any bytes below the start offset of the first word. It then pushes the remaining bytes in the byte order chosen by a control bit, and it waits whenever the FIFO signals full.

Each pushed byte advances the address register by one and lowers the count register by one, so software always sees the next byte to fetch and the bytes still owed. When the count reaches zero, a sticky done flag is set and the block stalls with no reads and no pushes. The flag can raise an interrupt. The stall lasts until software writes a new nonzero count, typically after pointing the address at the next buffer.

Top module: `bsin_fetch_top`

## Requirements
- R1: After reset the address, count and control registers read 0, the status register reads 0, and `mem_req`, `fifo_push` and `irq` are low.
- R2: The register port decodes `reg_addr` as follows: 0 is the address, 1 is the count, 2 is control (bit 0 selects little-endian, bit 1 enables the interrupt), and 3 is status (bit 0 is done). Reads are combinational. Writes take effect at the clock edge where `reg_wr_en` is high.
- R3: In the cycle after a nonzero count is written, `mem_req` is high with `mem_req_addr` equal to the address register with its two low bits cleared. Writing a count of zero starts nothing.
- R4: For any start address, the first byte pushed is the one at the start address. Bytes of the first word below the start offset are never pushed.
- R5: When control bit 0 is 0, the byte at offset k of a word is `mem_rsp_data[31-8k -: 8]`. When control bit 0 is 1, it is `mem_rsp_data[8k +: 8]`.
- R6: Each pushed byte adds one to the address register and subtracts one from the count register. Neither register changes in a cycle with no push and no write.
- R7: `fifo_push` is never high while `fifo_full` is high. Pushing resumes once full drops, and no byte is lost.
- R8: At most one memory read is outstanding. A new request is made only after the previous response has arrived.
- R9: When the count reaches zero, status bit 0 is set and stays set. No further requests or pushes occur until a nonzero count is written, so exactly the programmed number of bytes is delivered.
- R10: Writing status with bit 0 set clears done. Writing status with bit 0 clear leaves done unchanged.
- R11: `irq` is high exactly when status bit 0 and control bit 1 are both set.
- R12: Writing the address or the count discards any buffered word and any response still in flight. Fetching restarts from the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Word-aligned read address |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Read data word |
| fifo_push | output | 1 | Push `fifo_byte` into the decoder FIFO |
| fifo_byte | output | 8 | Byte being pushed |
| fifo_full | input | 1 | FIFO cannot take a byte this cycle |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the edge that samples it. The bench therefore reads the registers, `mem_req` and `mem_req_addr` one cycle after the write is driven, and it checks the R3 request exactly there. A response captured at an edge can be pushed in the next cycle. Each push updates the address and the count at the edge that accepts the byte. Because of this, the bench samples pushes, requests and responses two nanoseconds after the falling edge, when every input driven at that falling edge has settled. It checks the final registers, done and `irq` only after polling sees done and a few idle cycles have passed, so that R9 also confirms that nothing extra is delivered. A sweep over both byte orders, all four start offsets, lengths of 1 to 9, and memory and FIFO stalls on or off compares every byte against a memory pattern computed from its address.

// File: rtl/bsin_pkg.sv
package bsin_pkg;

    typedef enum logic [1:0] {
        CSR_ADDR   = 2'd0,
        CSR_COUNT  = 2'd1,
        CSR_CTRL   = 2'd2,
        CSR_STATUS = 2'd3
    } csr_sel_e;

    localparam int CTRL_LE_BIT   = 0;
    localparam int CTRL_IEN_BIT  = 1;
    localparam int STAT_DONE_BIT = 0;

endpackage

// File: rtl/bsin_cursor.sv
module bsin_cursor #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [31:0]       wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              active,
    output logic              final_byte
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } cur_t;

    cur_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (ld_addr) begin
            cur_d.addr = wdata[ADDR_W-1:0];
        end else if (step) begin
            cur_d.addr = cur_q.addr + ADDR_W'(1);
        end
        if (ld_cnt) begin
            cur_d.cnt = wdata[CNT_W-1:0];
        end else if (step) begin
            cur_d.cnt = cur_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign addr       = cur_q.addr;
    assign cnt        = cur_q.cnt;
    assign active     = (cur_q.cnt != '0);
    assign final_byte = (cur_q.cnt == CNT_W'(1));

endmodule

// File: rtl/bsin_reader.sv
module bsin_reader #(
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               flush,
    input  logic               consume_last,
    input  logic [WADDR_W-1:0] word_addr,
    output logic               mem_req,
    output logic [WADDR_W-1:0] mem_word_addr,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [DATA_W-1:0]  mem_rsp_data,
    output logic               buf_valid,
    output logic [DATA_W-1:0]  buf_word,
    output logic               rd_out
);

    typedef struct packed {
        logic              pend;
        logic              stale;
        logic              bvalid;
        logic [DATA_W-1:0] bword;
    } rd_t;

    rd_t rd_d, rd_q;
    logic accept;

    assign mem_req       = active && !rd_q.bvalid && !rd_q.pend;
    assign mem_word_addr = word_addr;
    assign accept        = mem_req && mem_req_ready;

    always_comb begin
        rd_d = rd_q;
        if (flush || consume_last) begin
            rd_d.bvalid = 1'b0;
        end
        if (accept) begin
            rd_d.pend  = 1'b1;
            rd_d.stale = flush;
        end else if (rd_q.pend && mem_rsp_valid) begin
            rd_d.pend  = 1'b0;
            rd_d.stale = 1'b0;
            if (!rd_q.stale && !flush) begin
                rd_d.bvalid = 1'b1;
                rd_d.bword  = mem_rsp_data;
            end
        end else if (rd_q.pend && flush) begin
            rd_d.stale = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign buf_valid = rd_q.bvalid;
    assign buf_word  = rd_q.bword;
    assign rd_out    = rd_q.pend;

endmodule

// File: rtl/bsin_lane.sv
module bsin_lane #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [OFF_W-1:0]  offset,
    input  logic              little,
    output logic [7:0]        byte_o
);

    logic [7:0] msb_first [BYTES];
    logic [7:0] lsb_first [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign msb_first[g] = word[DATA_W-1-8*g -: 8];
        assign lsb_first[g] = word[8*g +: 8];
    end

    assign byte_o = little ? lsb_first[offset] : msb_first[offset];

endmodule

// File: rtl/bsin_csr.sv
module bsin_csr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       wr_status,
    input  logic [1:0] ctrl_wdata,
    input  logic       status_wdata,
    input  logic       done_set,
    output logic       little,
    output logic       irq_en,
    output logic       done
);

    typedef struct packed {
        logic little;
        logic irq_en;
        logic done;
    } csr_t;

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (wr_ctrl) begin
            csr_d.little = ctrl_wdata[bsin_pkg::CTRL_LE_BIT];
            csr_d.irq_en = ctrl_wdata[bsin_pkg::CTRL_IEN_BIT];
        end
        if (done_set) begin
            csr_d.done = 1'b1;
        end else if (wr_status && status_wdata) begin
            csr_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    assign little = csr_q.little;
    assign irq_en = csr_q.irq_en;
    assign done   = csr_q.done;

endmodule

// File: rtl/bsin_fetch_top.sv
module bsin_fetch_top #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    localparam int BYTES   = DATA_W / 8,
    localparam int OFF_W   = $clog2(BYTES),
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              fifo_push,
    output logic [7:0]        fifo_byte,
    input  logic              fifo_full,
    output logic              irq
);

    import bsin_pkg::*;

    logic              wr_addr_s, wr_cnt_s, wr_ctrl_s, wr_stat_s;
    logic [ADDR_W-1:0] addr_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              active_w, final_w;
    logic              buf_valid_w, rd_out_w;
    logic [DATA_W-1:0] buf_word_w;
    logic [WADDR_W-1:0] req_word_w;
    logic              little_w, irq_en_w, done_w;
    logic              word_end_w, consume_last_w, done_set_w, flush_w;

    assign wr_addr_s = reg_wr_en && (csr_sel_e'(reg_addr) == CSR_ADDR);
    assign wr_cnt_s  = reg_wr_en && (csr_sel_e'(reg_addr) == CSR_COUNT);
    assign wr_ctrl_s = reg_wr_en && (csr_sel_e'(reg_addr) == CSR_CTRL);
    assign wr_stat_s = reg_wr_en && (csr_sel_e'(reg_addr) == CSR_STATUS);
    assign flush_w   = wr_addr_s || wr_cnt_s;

    assign fifo_push      = buf_valid_w && active_w && !fifo_full;
    assign word_end_w     = (addr_w[OFF_W-1:0] == {OFF_W{1'b1}});
    assign consume_last_w = fifo_push && (word_end_w || final_w);
    assign done_set_w     = fifo_push && final_w && !wr_cnt_s;

    bsin_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) cursor_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_addr    (wr_addr_s),
        .ld_cnt     (wr_cnt_s),
        .wdata      (reg_wdata),
        .step       (fifo_push),
        .addr       (addr_w),
        .cnt        (cnt_w),
        .active     (active_w),
        .final_byte (final_w)
    );

    bsin_reader #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) reader_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active_w),
        .flush         (flush_w),
        .consume_last  (consume_last_w),
        .word_addr     (addr_w[ADDR_W-1:OFF_W]),
        .mem_req       (mem_req),
        .mem_word_addr (req_word_w),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .buf_valid     (buf_valid_w),
        .buf_word      (buf_word_w),
        .rd_out        (rd_out_w)
    );

    assign mem_req_addr = {req_word_w, {OFF_W{1'b0}}};

    bsin_lane #(.DATA_W(DATA_W)) lane_i (
        .word   (buf_word_w),
        .offset (addr_w[OFF_W-1:0]),
        .little (little_w),
        .byte_o (fifo_byte)
    );

    bsin_csr csr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ctrl      (wr_ctrl_s),
        .wr_status    (wr_stat_s),
        .ctrl_wdata   (reg_wdata[1:0]),
        .status_wdata (reg_wdata[STAT_DONE_BIT]),
        .done_set     (done_set_w),
        .little       (little_w),
        .irq_en       (irq_en_w),
        .done         (done_w)
    );

    assign irq = done_w && irq_en_w;

    always_comb begin
        reg_rdata = '0;
        case (csr_sel_e'(reg_addr))
            CSR_ADDR:   reg_rdata = 32'(addr_w);
            CSR_COUNT:  reg_rdata = 32'(cnt_w);
            CSR_CTRL:   reg_rdata = {30'd0, irq_en_w, little_w};
            CSR_STATUS: reg_rdata = {31'd0, done_w};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bsin_fetch_chk.sv
module bsin_fetch_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [1:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              mem_req,
    input logic              fifo_push,
    input logic              fifo_full,
    input logic              rd_out,
    input logic [CNT_W-1:0]  cnt,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);

    assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_push);

    assert_idle_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (!fifo_push && !mem_req));

    assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |-> !mem_req);

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && !(reg_wr_en && reg_addr == 2'd1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_push && !reg_wr_en) |=> $stable(addr));

    assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(fifo_push) && $past(cnt) == CNT_W'(1)));

    assert_done_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 2'd3 && reg_wdata[0] && !(fifo_push && cnt == CNT_W'(1)))
        |=> !done);

endmodule

bind bsin_fetch_top bsin_fetch_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .fifo_push (fifo_push),
    .fifo_full (fifo_full),
    .rd_out    (rd_out_w),
    .cnt       (cnt_w),
    .addr      (addr_w),
    .done      (done_w)
);

// File: tb/bsin_fetch_top_tb_top.sv
module bsin_fetch_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        fifo_push;
    logic [7:0]  fifo_byte;
    logic        fifo_full = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int ncap = 0;
    logic [7:0] cap [64];
    int full_viol = 0;
    int out_viol = 0;
    int req_n = 0;
    int rsp_n = 0;
    bit bp_mode = 1'b0;
    bit force_full = 1'b0;
    int lat = 1;
    int wait_left = 0;
    logic [31:0] pend_addr = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bsin_fetch_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .mem_req       (mem_req),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .fifo_push     (fifo_push),
        .fifo_byte     (fifo_byte),
        .fifo_full     (fifo_full),
        .irq           (irq)
    );

    function automatic logic [7:0] bval(input logic [31:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hC3;
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] w);
        return {bval(w), bval(w + 1), bval(w + 2), bval(w + 3)};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [31:0] a, input bit le);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return le ? bval(w + 3 - {30'd0, a[1:0]}) : bval(a);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder and stall driver, acting on falling edges
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fifo_full     = force_full | (bp_mode & lfsr[0] & lfsr[5]);
            mem_req_ready = !bp_mode | lfsr[3];
            mem_rsp_valid = 1'b0;
            if (wait_left > 0) begin
                wait_left--;
                if (wait_left == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = word_at(pend_addr);
                end
            end else if (mem_req && mem_req_ready) begin
                pend_addr = mem_req_addr;
                wait_left = lat;
            end
        end
    end

    // monitor, sampling after inputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (fifo_push) begin
                    if (ncap < 64) cap[ncap] = fifo_byte;
                    ncap++;
                    if (fifo_full) full_viol++;
                end
                if (mem_req && mem_req_ready) req_n++;
                if (mem_rsp_valid) rsp_n++;
                if (req_n - rsp_n > 1) out_viol++;
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] s;
        ok = 1'b0;
        for (int t = 0; t < 600; t++) begin
            @(negedge clk);
            #3;
            reg_read(2'd3, s);
            if (s[0]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic run_case(input bit le, input int off, input int len, input int idx);
        logic [31:0] start, r;
        bit ok, ien;
        ien   = off[0];
        start = 32'h1000 + 32'(idx) * 32'h40 + 32'(off);
        lat   = ((off + len) % 3) + 1;
        reg_write(2'd2, {30'd0, ien, le});
        reg_write(2'd0, start);
        ncap = 0;
        reg_write(2'd1, 32'(len));
        chk(mem_req === 1'b1, "R3 request after count write", {31'd0, mem_req}, 32'd1);
        chk(mem_req_addr === {start[31:2], 2'b00}, "R3 aligned read address",
            mem_req_addr, {start[31:2], 2'b00});
        wait_done(ok);
        chk(ok, "R9 done reached", {31'd0, ok}, 32'd1);
        repeat (4) @(negedge clk);
        #3;
        chk(ncap == len, "R9 byte total", 32'(ncap), 32'(len));
        for (int i = 0; i < len && i < 64; i++) begin
            logic [7:0] e;
            e = exp_byte(start + 32'(i), le);
            if (i == 0)
                chk(cap[i] === e, "R4 first byte at start offset", {24'd0, cap[i]}, {24'd0, e});
            else
                chk(cap[i] === e, "R5 byte order", {24'd0, cap[i]}, {24'd0, e});
        end
        reg_read(2'd0, r);
        chk(r === start + 32'(len), "R6 final address", r, start + 32'(len));
        reg_read(2'd1, r);
        chk(r === 32'd0, "R6 final count", r, 32'd0);
        chk(irq === ien, "R11 irq level", {31'd0, irq}, {31'd0, ien});
        chk(mem_req === 1'b0, "R9 stalled no request", {31'd0, mem_req}, 32'd0);
        if (len == 2) begin
            reg_write(2'd3, 32'd0);
            reg_read(2'd3, r);
            chk(r[0] === 1'b1, "R10 zero write keeps done", r, 32'd1);
        end
        reg_write(2'd3, 32'd1);
        reg_read(2'd3, r);
        chk(r[0] === 1'b0, "R10 done cleared", r, 32'd0);
        chk(irq === 1'b0, "R11 irq after clear", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        bit ok;
        int idx;
        repeat (5) @(negedge clk);
        #1;
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), r);
            chk(r === 32'd0, "R1 register reset value", r, 32'd0);
        end
        chk(mem_req === 1'b0 && fifo_push === 1'b0 && irq === 1'b0, "R1 outputs idle",
            {29'd0, mem_req, fifo_push, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;

        // zero count starts nothing
        reg_write(2'd0, 32'h0000_0123);
        reg_write(2'd1, 32'd0);
        chk(mem_req === 1'b0, "R3 zero count no request", {31'd0, mem_req}, 32'd0);
        repeat (5) @(negedge clk);
        #3;
        chk(ncap == 0, "R3 zero count no push", 32'(ncap), 32'd0);
        reg_read(2'd0, r);
        chk(r === 32'h123, "R2 address readback", r, 32'h123);
        reg_write(2'd2, 32'd3);
        reg_read(2'd2, r);
        chk(r === 32'd3, "R2 control readback", r, 32'd3);

        // sweep
        idx = 0;
        for (int bp = 0; bp < 2; bp++) begin
            bp_mode = bp[0];
            for (int le = 0; le < 2; le++) begin
                for (int off = 0; off < 4; off++) begin
                    for (int len = 1; len <= 9; len++) begin
                        run_case(le[0], off, len, idx);
                        idx++;
                    end
                end
            end
        end
        bp_mode = 1'b0;

        // reprogram while a word is buffered (R12)
        lat = 2;
        reg_write(2'd2, 32'd0);
        force_full = 1'b1;
        reg_write(2'd0, 32'h0000_2000);
        ncap = 0;
        reg_write(2'd1, 32'd8);
        repeat (6) @(negedge clk);
        reg_write(2'd0, 32'h0000_3005);
        reg_write(2'd1, 32'd3);
        force_full = 1'b0;
        wait_done(ok);
        repeat (3) @(negedge clk);
        #3;
        chk(ok && ncap == 3, "R12 buffered word dropped count", 32'(ncap), 32'd3);
        for (int i = 0; i < 3; i++)
            chk(cap[i] === bval(32'h3005 + 32'(i)), "R12 bytes from new address",
                {24'd0, cap[i]}, {24'd0, bval(32'h3005 + 32'(i))});
        reg_write(2'd3, 32'd1);

        // reprogram while a read is in flight (R12)
        lat = 3;
        reg_write(2'd0, 32'h0000_4000);
        ncap = 0;
        reg_write(2'd1, 32'd4);
        reg_write(2'd0, 32'h0000_4411);
        wait_done(ok);
        repeat (3) @(negedge clk);
        #3;
        chk(ok && ncap == 4, "R12 in-flight response dropped count", 32'(ncap), 32'd4);
        for (int i = 0; i < 4; i++)
            chk(cap[i] === bval(32'h4411 + 32'(i)), "R12 in-flight bytes from new address",
                {24'd0, cap[i]}, {24'd0, bval(32'h4411 + 32'(i))});
        reg_write(2'd3, 32'd1);

        chk(full_viol == 0, "R7 push while full", 32'(full_viol), 32'd0);
        chk(out_viol == 0, "R8 reads outstanding above one", 32'(out_viol), 32'd0);
        finish_run();
    end

endmodule